// File: doc/BRIEF.md
# Transmit Command Word Parser

This block sits behind the transmit data port of an Ethernet controller. Software writes 32-bit words into a small input word FIFO. Each transmit buffer in that stream starts with two command words, called first command and second command. The first command gives the byte count of the buffer, the byte offset at which valid data starts, the segment flags and the alignment of the end of the buffer. The second command carries a 16-bit tag in its upper half. The packed data words follow, then any alignment pad words. The parser drops the leading offset bytes and the pad words. It sends the payload out one byte per cycle, lowest byte of each word first, and marks the first byte of a frame and the last byte of a frame.

When a buffer flagged as the last segment of a frame completes, the parser pushes a status word into a 512-entry status FIFO. The status word holds the tag in its upper 16 bits and zero in its lower 16 bits. A pop port reads the head of the status FIFO and a peek port shows the head without removing it. The block gives one-cycle pulses for three events: buffer completion with a notify request, a write that arrives while the input FIFO is full, and the status FIFO reaching capacity. A soft-clear input abandons the buffer in progress.

The state machine has three states. ST_IDLE waits for the first command. ST_CMDB waits for the second command. ST_DATA walks the data and pad words. It makes these transitions:
- ST_IDLE→ST_CMDB: a word is taken while idle.
- ST_CMDB→ST_DATA: a word is taken as the second command.
- ST_DATA→ST_IDLE: the buffer finishes, meaning no word is held and none is left to take.
- any state→ST_IDLE: soft clear.

Top module: `txcmd_parser`

## Requirements
- R1: After reset, tx_valid, all three pulses and stat_level are 0, and cmd_a_o and cmd_b_o are all ones.
- R2: In idle, the next input word is latched as the first command, ANDed with 0x831F37FF. The word after it is latched unmasked as the second command, and then the data words of the buffer follow.
- R3: Byte count is first-command bits 10:0 and start offset is bits 20:16. The output carries exactly byte-count bytes, taken from the words little-endian (byte position p of the buffer is word p/4, bits 8*(p%4)+7:8*(p%4)), starting at position offset. An offset of 4 or more skips whole words.
- R4: The buffer takes ceil((count+offset)/4) data words plus pad words. First-command bits 25:24 select the padding: 01 rounds the word total up to a multiple of 4, 10 rounds it up to a multiple of 8, and 00 or 11 add no pad. Pad words produce no output, and the next word is a new first command.
- R5: If first-command bit 13 (first segment) is set, tx_sof is raised with the buffer's first output byte. If bit 12 (last segment) is set, tx_eof is raised with its last output byte.
- R6: When a buffer with bit 12 set finishes, {cmd_b[31:16],16'h0000} is appended to the status FIFO if it holds fewer than 512 entries. If the FIFO is full, the status word is dropped.
- R7: stat_full_pulse is raised for one cycle when a push brings the status FIFO to 512 entries, and at no other time.
- R8: When a buffer with first-command bit 31 set finishes, done_pulse is raised for one cycle.
- R9: A write that arrives while the input word FIFO holds its full depth of words raises ovf_pulse one cycle later and is discarded.
- R10: Soft clear returns the parser to idle, sets both command registers to all ones and drops queued and held data words. The status FIFO is left unchanged.
- R11: stat_peek shows the head status word. A pop loads the head into stat_pop_word and advances only when the status FIFO is not empty, so a pop on an empty FIFO leaves stat_level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soft_clr | input | 1 | Abandon the current buffer and flush the input words |
| wr_en | input | 1 | Write strobe for the data port |
| wr_word | input | 32 | Word written to the data port |
| stat_pop | input | 1 | Pop the status FIFO head |
| ovf_pulse | output | 1 | Input word FIFO overflow, one cycle |
| tx_valid | output | 1 | Output byte valid |
| tx_byte | output | 8 | Output byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| done_pulse | output | 1 | Buffer finished with a notify request |
| stat_full_pulse | output | 1 | Status FIFO reached capacity |
| stat_pop_word | output | 32 | Word returned by the last pop |
| stat_peek | output | 32 | Current head of the status FIFO |
| stat_level | output | $clog2(STAT_DEPTH+1) | Status FIFO occupancy |
| cmd_a_o | output | 32 | Latched first command |
| cmd_b_o | output | 32 | Latched second command |

## Verification
The hardest conditions to reach are a full status FIFO and an input FIFO overflow. The bench sends 512 zero-length last-segment buffers back to back to fill the status FIFO. It then sends one more buffer and checks that this status word is dropped and that no second full pulse appears. For the overflow, it writes a burst of data words with no gaps while the parser is still spending five cycles on each word. It then soft-clears and checks that none of the dropped words reach a later frame. The rest of the traffic is random buffers with random counts, offsets, padding and flags, with reserved command bits filled with random junk. Each output byte and each status tag is compared with values that the bench predicts from the command words.

// File: rtl/txp_pkg.sv
package txp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMDB = 2'd1,
        ST_DATA = 2'd2
    } txp_state_e;

    localparam logic [31:0] CMDA_KEEP = 32'h831F_37FF;
    localparam int          LAST_BIT  = 12;
    localparam int          FIRST_BIT = 13;
    localparam int          NOTIFY_BIT = 31;

    // data words plus pad words for one buffer
    function automatic logic [11:0] buffer_words(input logic [31:0] a);
        logic [11:0] n;
        logic [11:0] m;
        n = (12'(a[10:0]) + 12'(a[20:16]) + 12'd3) >> 2;
        case (a[25:24])
            2'b01:   m = 12'd3;
            2'b10:   m = 12'd7;
            default: m = 12'd0;
        endcase
        return n + ((~n + 12'd1) & m);
    endfunction

endpackage

// File: rtl/txp_word_fifo.sv
module txp_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= step(wp);
            if (pop_ok)  rp <= step(rp);
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);

endmodule

// File: rtl/txp_stat_fifo.sv
module txp_stat_fifo #(
    parameter int DEPTH = 512,
    parameter int TW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [TW-1:0]              tag,
    input  logic                       pop,
    output logic [TW-1:0]              head_tag,
    output logic [TW-1:0]              pop_tag,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [TW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          empty, push_ok, pop_ok;

    assign empty    = (level == '0);
    assign full     = (level == CW'(DEPTH));
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;
    assign head_tag = mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            level   <= '0;
            pop_tag <= '0;
        end else begin
            if (pop)     pop_tag <= mem[rp];
            if (push_ok) wp <= step(wp);
            if (pop_ok)  rp <= step(rp);
            level <= level + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (level == '0));

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/txcmd_parser.sv
module txcmd_parser #(
    parameter int DFIFO_DEPTH = 4,
    parameter int STAT_DEPTH  = 512
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            soft_clr,
    input  logic                            wr_en,
    input  logic [31:0]                     wr_word,
    input  logic                            stat_pop,
    output logic                            ovf_pulse,
    output logic                            tx_valid,
    output logic [7:0]                      tx_byte,
    output logic                            tx_sof,
    output logic                            tx_eof,
    output logic                            done_pulse,
    output logic                            stat_full_pulse,
    output logic [31:0]                     stat_pop_word,
    output logic [31:0]                     stat_peek,
    output logic [$clog2(STAT_DEPTH+1)-1:0] stat_level,
    output logic [31:0]                     cmd_a_o,
    output logic [31:0]                     cmd_b_o
);
    import txp_pkg::*;

    localparam int LW = $clog2(STAT_DEPTH + 1);

    txp_state_e  state_q, state_d;
    logic [31:0] cmd_a_q, cmd_b_q, word_q;
    logic        hold_q;
    logic [11:0] pos_q, words_left_q;

    logic [31:0] wf_dout;
    logic        wf_empty, wf_full, wf_pop;
    logic [15:0] head_tag, pop_tag;
    logic        sf_full;

    logic [11:0] size_b, ofs_b;
    logic        in_range, finish, stat_push, full_hit;

    txp_word_fifo #(.W(32), .DEPTH(DFIFO_DEPTH)) u_words (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .push(wr_en), .din(wr_word), .pop(wf_pop),
        .dout(wf_dout), .empty(wf_empty), .full(wf_full)
    );

    txp_stat_fifo #(.DEPTH(STAT_DEPTH), .TW(16)) u_stat (
        .clk(clk), .rst_n(rst_n), .push(stat_push), .tag(cmd_b_q[31:16]),
        .pop(stat_pop), .head_tag(head_tag), .pop_tag(pop_tag),
        .level(stat_level), .full(sf_full)
    );

    assign size_b    = 12'(cmd_a_q[10:0]);
    assign ofs_b     = 12'(cmd_a_q[20:16]);
    assign in_range  = hold_q && (pos_q >= ofs_b) && (pos_q < ofs_b + size_b);
    assign finish    = (state_q == ST_DATA) && !hold_q && (words_left_q == '0);
    assign stat_push = finish && cmd_a_q[LAST_BIT];
    assign full_hit  = stat_push && !sf_full && !stat_pop
                       && (stat_level == LW'(STAT_DEPTH - 1));
    assign wf_pop    = !soft_clr && !wf_empty &&
                       ((state_q == ST_IDLE) || (state_q == ST_CMDB) ||
                        ((state_q == ST_DATA) && !hold_q && (words_left_q != '0)));

    assign stat_peek     = {head_tag, 16'h0000};
    assign stat_pop_word = {pop_tag, 16'h0000};
    assign cmd_a_o       = cmd_a_q;
    assign cmd_b_o       = cmd_b_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wf_pop) state_d = ST_CMDB;
            ST_CMDB: if (wf_pop) state_d = ST_DATA;
            ST_DATA: if (finish) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (soft_clr) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_a_q         <= '1;
            cmd_b_q         <= '1;
            word_q          <= '0;
            hold_q          <= 1'b0;
            pos_q           <= '0;
            words_left_q    <= '0;
            tx_valid        <= 1'b0;
            tx_byte         <= '0;
            tx_sof          <= 1'b0;
            tx_eof          <= 1'b0;
            done_pulse      <= 1'b0;
            stat_full_pulse <= 1'b0;
            ovf_pulse       <= 1'b0;
        end else begin
            tx_valid        <= 1'b0;
            tx_sof          <= 1'b0;
            tx_eof          <= 1'b0;
            done_pulse      <= 1'b0;
            stat_full_pulse <= 1'b0;
            ovf_pulse       <= wr_en && wf_full && !soft_clr;
            if (soft_clr) begin
                cmd_a_q      <= '1;
                cmd_b_q      <= '1;
                hold_q       <= 1'b0;
                pos_q        <= '0;
                words_left_q <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: if (wf_pop) cmd_a_q <= wf_dout & CMDA_KEEP;
                    ST_CMDB: if (wf_pop) begin
                        cmd_b_q      <= wf_dout;
                        words_left_q <= buffer_words(cmd_a_q);
                        pos_q        <= '0;
                        hold_q       <= 1'b0;
                    end
                    ST_DATA: begin
                        if (wf_pop) begin
                            word_q <= wf_dout;
                            hold_q <= 1'b1;
                        end
                        if (hold_q) begin
                            if (in_range) begin
                                tx_valid <= 1'b1;
                                tx_byte  <= word_q[{pos_q[1:0], 3'b000} +: 8];
                                tx_sof   <= cmd_a_q[FIRST_BIT] && (pos_q == ofs_b);
                                tx_eof   <= cmd_a_q[LAST_BIT] &&
                                            (pos_q == ofs_b + size_b - 12'd1);
                            end
                            pos_q <= pos_q + 12'd1;
                            if (pos_q[1:0] == 2'd3) begin
                                hold_q       <= 1'b0;
                                words_left_q <= words_left_q - 12'd1;
                            end
                        end
                        if (finish) begin
                            done_pulse      <= cmd_a_q[NOTIFY_BIT];
                            stat_full_pulse <= full_hit;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5
    sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof || tx_eof) |-> tx_valid);

    // R9
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(wr_en));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (cmd_a_o == '1 && cmd_b_o == '1 && !tx_valid));

    // R7
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_full_pulse |-> (stat_level == LW'(STAT_DEPTH)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

endmodule

// File: tb/sim_txcmd_parser.sv
module sim_txcmd_parser;

    localparam int SDEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic        stat_pop = 1'b0;
    logic        ovf_pulse, tx_valid, tx_sof, tx_eof, done_pulse, stat_full_pulse;
    logic [7:0]  tx_byte;
    logic [31:0] stat_pop_word, stat_peek, cmd_a_o, cmd_b_o;
    logic [9:0]  stat_level;

    txcmd_parser #(.DFIFO_DEPTH(4), .STAT_DEPTH(SDEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_en),
        .wr_word(wr_word), .stat_pop(stat_pop), .ovf_pulse(ovf_pulse),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .done_pulse(done_pulse), .stat_full_pulse(stat_full_pulse),
        .stat_pop_word(stat_pop_word), .stat_peek(stat_peek),
        .stat_level(stat_level), .cmd_a_o(cmd_a_o), .cmd_b_o(cmd_b_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int mon_chk = 0, mon_bad = 0;
    int done_seen = 0, ovf_seen = 0, full_seen = 0, done_exp = 0;
    bit mon_en = 1'b1;
    logic [9:0]  exp_q [$];
    logic [15:0] tag_q [$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 n_chk + mon_chk, n_bad + mon_bad);
        $finish;
    endtask

    // byte monitor and pulse counters
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && mon_en) begin
                mon_chk++;
                if (exp_q.size() == 0) begin
                    mon_bad++;
                    $display("FAIL R3: actual byte %h expected none", tx_byte);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    if ({tx_sof, tx_eof, tx_byte} !== e) begin
                        mon_bad++;
                        $display("FAIL R3/R5: actual %h expected %h",
                                 {tx_sof, tx_eof, tx_byte}, e);
                    end
                end
            end
            if (done_pulse)      done_seen++;
            if (ovf_pulse)       ovf_seen++;
            if (stat_full_pulse) full_seen++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] w, input int gap);
        wr_en = 1'b1;
        wr_word = w;
        @(negedge clk);
        wr_en = 1'b0;
        idle(gap);
    endtask

    task automatic pop();
        stat_pop = 1'b1;
        @(negedge clk);
        stat_pop = 1'b0;
    endtask

    task automatic pulse_clear();
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
    endtask

    // build one buffer, predict its bytes and status, and write it
    task automatic send_buf(input int size, input int ofs, input int align,
                            input bit first, input bit last, input bit ioc,
                            input logic [15:0] tag, input int gap);
        logic [31:0] a, b, w;
        int n, m, pad;
        a = $urandom & 32'h7CE0_C800;
        a[10:0]  = 11'(size);
        a[20:16] = 5'(ofs);
        a[25:24] = 2'(align);
        a[12] = last;
        a[13] = first;
        a[31] = ioc;
        b = {tag, 16'($urandom)};
        n = (size + ofs + 3) / 4;
        m = (align == 1) ? 4 : (align == 2) ? 8 : 1;
        pad = (m - (n % m)) % m;
        wr(a, gap);
        wr(b, gap);
        for (int wi = 0; wi < n + pad; wi++) begin
            w = $urandom;
            for (int j = 0; j < 4; j++) begin
                int p;
                p = wi * 4 + j;
                if (wi < n && p >= ofs && p < ofs + size) begin
                    logic [7:0] d;
                    d = 8'($urandom);
                    w[8*j +: 8] = d;
                    exp_q.push_back({first && (p == ofs), last && (p == ofs + size - 1), d});
                end
            end
            wr(w, gap);
        end
        if (last) tag_q.push_back(tag);
        if (ioc) done_exp++;
        if (gap >= 6) begin
            check("R2 first command masked", cmd_a_o, a & 32'h831F_37FF);
            check("R2 second command", cmd_b_o, b);
        end
    endtask

    initial begin
        int base;
        void'($urandom(32'h1D5E_ED01));
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        check("R1 cmd_a", cmd_a_o, 32'hFFFF_FFFF);
        check("R1 cmd_b", cmd_b_o, 32'hFFFF_FFFF);
        check("R1 level", {22'd0, stat_level}, 32'd0);
        check("R1 pulses", {29'd0, ovf_pulse, done_pulse, stat_full_pulse}, 32'd0);

        // R2 masking of the first command, then R10 clear
        wr(32'hFFFF_FFFF, 1);
        check("R2 mask", cmd_a_o, 32'h831F_37FF);
        wr(32'h1234_5678, 1);
        check("R2 second word", cmd_b_o, 32'h1234_5678);
        pulse_clear();
        check("R10 cmd_a ones", cmd_a_o, 32'hFFFF_FFFF);
        check("R10 cmd_b ones", cmd_b_o, 32'hFFFF_FFFF);

        // directed buffers: R3 R4 R5 R8
        send_buf(1, 0, 0, 1, 1, 0, 16'hA001, 6);
        send_buf(5, 6, 1, 1, 1, 1, 16'hA002, 6);
        send_buf(0, 0, 0, 0, 1, 1, 16'hA003, 6);
        send_buf(13, 3, 2, 1, 1, 0, 16'hA004, 6);
        send_buf(7, 1, 0, 1, 0, 0, 16'hA005, 6);
        send_buf(9, 31, 2, 0, 1, 1, 16'hA006, 6);

        // random buffers
        for (int i = 0; i < 40; i++) begin
            send_buf($urandom_range(0, 40), $urandom_range(0, 9), $urandom_range(0, 3),
                     1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 6);
        end
        idle(10);
        check("R3 all bytes seen", exp_q.size(), 0);
        check("R8 notify count", done_seen, done_exp);
        check("R9 no overflow under pacing", ovf_seen, 0);
        check("R6 status level", {22'd0, stat_level}, tag_q.size());

        // R11 drain with peek and pop
        while (tag_q.size() > 0) begin
            logic [15:0] t;
            t = tag_q.pop_front();
            check("R11 peek", stat_peek, {t, 16'h0});
            pop();
            check("R11 pop word", stat_pop_word, {t, 16'h0});
        end
        check("R11 drained", {22'd0, stat_level}, 32'd0);
        pop();
        check("R11 empty pop level", {22'd0, stat_level}, 32'd0);

        // R6 R7 fill status FIFO
        base = full_seen;
        for (int i = 0; i < SDEPTH; i++) begin
            wr(32'h0000_1000, 0);
            wr({16'(i + 16'h0100), 16'hFFFF}, 2);
        end
        idle(6);
        check("R6 level at capacity", {22'd0, stat_level}, SDEPTH);
        check("R7 one full pulse", full_seen - base, 1);
        wr(32'h0000_1000, 0);
        wr(32'hBEEF_0000, 4);
        check("R6 dropped when full", {22'd0, stat_level}, SDEPTH);
        check("R7 no repeat pulse", full_seen - base, 1);
        pop();
        check("R11 first popped", stat_pop_word, 32'h0100_0000);
        check("R11 peek after pop", stat_peek, 32'h0101_0000);
        for (int i = 1; i < SDEPTH; i++) begin
            pop();
            check("R6 order after fill", stat_pop_word, {16'(i + 16'h0100), 16'h0});
        end
        check("R11 level empty", {22'd0, stat_level}, 32'd0);

        // R9 overflow then R10 clear
        send_buf(4, 0, 0, 1, 1, 0, 16'hCAFE, 6);
        mon_en = 1'b0;
        base = ovf_seen;
        wr(32'h0000_0040, 0);
        wr(32'h5555_0000, 0);
        for (int i = 0; i < 12; i++) wr(32'hDEAD_0000 + i, 0);
        idle(2);
        check("R9 overflow flagged", (ovf_seen > base) ? 1 : 0, 1);
        pulse_clear();
        check("R10 cmd_a after clear", cmd_a_o, 32'hFFFF_FFFF);
        check("R10 status kept", {22'd0, stat_level}, 32'd1);
        check("R10 status head kept", stat_peek, 32'hCAFE_0000);
        idle(3);
        mon_en = 1'b1;
        exp_q.delete();
        send_buf(6, 2, 0, 1, 1, 0, 16'hF00D, 6);
        idle(6);
        check("R10 clean frame after clear", exp_q.size(), 0);
        check("R10 level after frame", {22'd0, stat_level}, 32'd2);
        finish_up();
    end

endmodule